// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside a memory endpoint and keeps the reservation bookkeeping for a set of hardware contexts that use load-linked and store-conditional sequences. Every request strobe brings an operation kind, a context number with a flag that says whether that number is meaningful, and a physical address. The block rounds each address down to a reservation line before it stores or compares it. A load-linked puts a reservation for the requesting context on that line. A store-conditional is let through only if its own context still holds a reservation on exactly that line.

When a store commits, whether it is a plain store or a store-conditional that succeeded, every reservation on the written line is dropped, whichever context owns it. Each owner that is not the requester receives a one-cycle clear-exclusive pulse. The data array itself lives elsewhere. The block only tells the memory whether the write may proceed and tells the requester the conditional result. There is one reservation slot per context, and every slot is compared in parallel, so each request gets its answer one cycle after the strobe.

Top module: `llsc_monitor`

## Requirements
- R1: Addresses are rounded down to a line of LINE_BYTES bytes (default 64) before they are stored or compared. Any two addresses that differ only in the low log2(LINE_BYTES) bits refer to the same reservation.
- R2: A load-linked (kind code 2'b01) from a valid context records a reservation. A later store-conditional (kind code 2'b10) from the same context to the same line then returns store-allowed 1 and SC result 1.
- R3: A context owns at most one reservation. A new load-linked from that context moves the reservation to the new line, so a store-conditional to the old line fails.
- R4: A store-conditional succeeds only when the requesting context holds a reservation on that line. A reservation held by another context on the same line does not count, and a store-conditional whose context flag is low always fails. A failure returns store-allowed 0 and SC result 0.
- R5: A failed store-conditional neither removes nor changes any reservation.
- R6: A plain store (kind code 2'b11) always returns store-allowed 1 and SC result 0, whatever reservations exist.
- R7: A committed store (a plain store or a successful store-conditional) removes every reservation on the written line, in all contexts.
- R8: For every reservation removed by a committed store, bit i of the clear-exclusive vector pulses for owner i, unless i is the requester's own valid context. A requester whose context flag is low gets a pulse for every owner.
- R9: Each request strobe produces exactly one response, with the response-valid output high in the following cycle. Back-to-back strobes are allowed. Clear-exclusive pulses last one cycle and only appear together with a response.
- R10: After reset there are no reservations, and every output is 0.
- R11: A load-linked whose context flag is low records nothing.
- R12: Kind code 2'b00 is a no-operation. It returns a response with store-allowed 0, SC result 0 and no pulses, and it leaves every reservation as it was. A load-linked response also has store-allowed 0 and SC result 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request strobe, one request per high cycle |
| req_kind_i | input | 2 | 00 no-op, 01 load-linked, 10 store-conditional, 11 plain store |
| req_ctx_i | input | CW | Requesting context number |
| req_ctx_valid_i | input | 1 | Context number is meaningful |
| req_addr_i | input | AW | Physical byte address |
| rsp_valid_o | output | 1 | Response for the request of the previous cycle |
| rsp_store_ok_o | output | 1 | Write may be committed to memory |
| rsp_sc_ok_o | output | 1 | Store-conditional result, 1 success, 0 failure |
| clr_excl_o | output | N | One-cycle clear-exclusive pulse per owning context |

## Verification
The assertions assume that reset is held for at least one clock edge and that the request inputs are known whenever the strobe is high. They also assume that a context number is below N whenever its flag is set. The bench always drives reset for several cycles, changes the request inputs only on falling edges, and takes context numbers from 0..N-1. Its irregular run includes requests with the context flag low, no-op codes and back-to-back strobes, but all of these stay legal.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        K_NOP = 2'b00,
        K_LL  = 2'b01,
        K_SC  = 2'b10,
        K_ST  = 2'b11
    } req_kind_e;

endpackage

// File: rtl/llsc_slot.sv
// One reservation slot: valid bit plus line address, owned by one context.
module llsc_slot #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_i,
    input  logic          clear_i,
    input  logic [AW-1:0] line_i,
    output logic          valid_o,
    output logic          hit_o
);

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] line;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (set_i) begin
            s_d.valid = 1'b1;
            s_d.line  = line_i;
        end else if (clear_i) begin
            s_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign valid_o = s_q.valid;
    assign hit_o   = s_q.valid && (s_q.line == line_i);

    // R5/R7: a slot is never set and cleared in the same cycle
    a_r7_set_clear_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_i && clear_i));

endmodule

// File: rtl/llsc_verdict.sv
// Combinational decision: which slots to set, clear and notify, and the response bits.
module llsc_verdict
    import llsc_pkg::*;
#(
    parameter int N  = 4,
    parameter int CW = 2
) (
    input  logic          req_valid_i,
    input  req_kind_e     kind_i,
    input  logic [CW-1:0] ctx_i,
    input  logic          ctx_valid_i,
    input  logic [N-1:0]  hit_i,
    output logic [N-1:0]  set_o,
    output logic [N-1:0]  clear_o,
    output logic [N-1:0]  notify_o,
    output logic          store_ok_o,
    output logic          sc_ok_o
);

    logic [N-1:0] is_self;
    logic         own_hit;
    logic         commit;

    for (genvar i = 0; i < N; i++) begin : g_self
        assign is_self[i] = ctx_valid_i && (ctx_i == CW'(i));
    end

    assign own_hit = |(is_self & hit_i);

    always_comb begin
        store_ok_o = 1'b0;
        sc_ok_o    = 1'b0;
        set_o      = '0;
        if (req_valid_i) begin
            unique case (kind_i)
                K_LL: set_o = is_self;
                K_SC: begin
                    store_ok_o = own_hit;
                    sc_ok_o    = own_hit;
                end
                K_ST: store_ok_o = 1'b1;
                default: ;
            endcase
        end
    end

    assign commit   = store_ok_o;
    assign clear_o  = commit ? hit_i : '0;
    assign notify_o = clear_o & ~is_self;

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter  int N          = 4,
    parameter  int AW         = 32,
    parameter  int LINE_BYTES = 64,
    localparam int CW         = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid_i,
    input  logic [1:0]    req_kind_i,
    input  logic [CW-1:0] req_ctx_i,
    input  logic          req_ctx_valid_i,
    input  logic [AW-1:0] req_addr_i,
    output logic          rsp_valid_o,
    output logic          rsp_store_ok_o,
    output logic          rsp_sc_ok_o,
    output logic [N-1:0]  clr_excl_o
);

    localparam int            OFS   = $clog2(LINE_BYTES);
    localparam logic [AW-1:0] LMASK = ~((AW'(1) << OFS) - AW'(1));

    typedef struct packed {
        logic         valid;
        logic         store_ok;
        logic         sc_ok;
        logic [N-1:0] clr;
    } rsp_t;

    rsp_t         r_d, r_q;
    req_kind_e    kind;
    logic [AW-1:0] line;
    logic [N-1:0] hit, set_v, clear_v, notify_v, slot_valid;
    logic         store_ok, sc_ok;

    assign kind = req_kind_e'(req_kind_i);
    assign line = req_addr_i & LMASK;

    for (genvar i = 0; i < N; i++) begin : g_slot
        llsc_slot #(.AW(AW)) slot_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (set_v[i]),
            .clear_i (clear_v[i]),
            .line_i  (line),
            .valid_o (slot_valid[i]),
            .hit_o   (hit[i])
        );
    end

    llsc_verdict #(.N(N), .CW(CW)) verdict_i (
        .req_valid_i (req_valid_i),
        .kind_i      (kind),
        .ctx_i       (req_ctx_i),
        .ctx_valid_i (req_ctx_valid_i),
        .hit_i       (hit),
        .set_o       (set_v),
        .clear_o     (clear_v),
        .notify_o    (notify_v),
        .store_ok_o  (store_ok),
        .sc_ok_o     (sc_ok)
    );

    always_comb begin
        r_d          = '0;
        r_d.valid    = req_valid_i;
        r_d.store_ok = store_ok;
        r_d.sc_ok    = sc_ok;
        r_d.clr      = notify_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_valid_o    = r_q.valid;
    assign rsp_store_ok_o = r_q.store_ok;
    assign rsp_sc_ok_o    = r_q.sc_ok;
    assign clr_excl_o     = r_q.clr;

    // R2: an SC success always comes with permission to store
    a_r2_sc_implies_store: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_sc_ok_o |-> rsp_store_ok_o);

    // R6: a plain store is always allowed and never reports SC success
    a_r6_plain_store_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_kind_i == 2'b11) |=> (rsp_store_ok_o && !rsp_sc_ok_o));

    // R5: a failed SC leaves the reservation set unchanged
    a_r5_failed_sc_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_kind_i == 2'b10) |=> (rsp_store_ok_o || $stable(slot_valid)));

    // R8: pulses only go to owners that held a reservation and lost it
    a_r8_notify_owner: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_excl_o & ~$past(slot_valid)) == '0) && ((clr_excl_o & slot_valid) == '0));

    // R9: one response per strobe, pulses only with a response
    a_r9_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_valid_o);
    a_r9_pulse_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_excl_o) |-> rsp_valid_o);

    // R12: no-op and load-linked responses carry no permission
    a_r12_nop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_kind_i[1]) |=> (!rsp_store_ok_o && clr_excl_o == '0));

endmodule

// File: tb/llsc_monitor_tb_top.sv
module llsc_monitor_tb_top;

    localparam int N  = 4;
    localparam int AW = 32;
    localparam int LB = 64;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid_i = 1'b0;
    logic [1:0]    req_kind_i = 2'b00;
    logic [CW-1:0] req_ctx_i = '0;
    logic          req_ctx_valid_i = 1'b0;
    logic [AW-1:0] req_addr_i = '0;
    logic          rsp_valid_o, rsp_store_ok_o, rsp_sc_ok_o;
    logic [N-1:0]  clr_excl_o;

    always #5 clk = ~clk;

    llsc_monitor #(.N(N), .AW(AW), .LINE_BYTES(LB)) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid_i     (req_valid_i),
        .req_kind_i      (req_kind_i),
        .req_ctx_i       (req_ctx_i),
        .req_ctx_valid_i (req_ctx_valid_i),
        .req_addr_i      (req_addr_i),
        .rsp_valid_o     (rsp_valid_o),
        .rsp_store_ok_o  (rsp_store_ok_o),
        .rsp_sc_ok_o     (rsp_sc_ok_o),
        .clr_excl_o      (clr_excl_o)
    );

    typedef struct {
        logic         so;
        logic         sc;
        logic [N-1:0] clr;
        string        tag;
    } exp_t;

    exp_t          sb_q[$];
    int            checks = 0;
    int            errors = 0;
    logic          mon_on = 1'b0;
    logic          m_v[N];
    logic [AW-1:0] m_a[N];

    function automatic logic [AW-1:0] lmask(logic [AW-1:0] a);
        return a & ~AW'(LB - 1);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // driver: applies one request and pushes the expected response
    task automatic issue(logic [1:0] k, int c, logic cv, logic [AW-1:0] a, string tag);
        exp_t e;
        logic [AW-1:0] m;
        logic own;
        @(negedge clk);
        req_valid_i = 1'b1;
        req_kind_i = k;
        req_ctx_i = CW'(c);
        req_ctx_valid_i = cv;
        req_addr_i = a;
        m = lmask(a);
        e.so = 1'b0; e.sc = 1'b0; e.clr = '0; e.tag = tag;
        own = cv && m_v[c] && (m_a[c] == m);
        if (k == 2'b01) begin
            if (cv) begin m_v[c] = 1'b1; m_a[c] = m; end
        end else if (k == 2'b10 || k == 2'b11) begin
            e.so = (k == 2'b11) || own;
            e.sc = (k == 2'b10) && own;
            if (e.so) begin
                for (int i = 0; i < N; i++) begin
                    if (m_v[i] && m_a[i] == m) begin
                        m_v[i] = 1'b0;
                        if (!(cv && c == i)) e.clr[i] = 1'b1;
                    end
                end
            end
        end
        sb_q.push_back(e);
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            req_valid_i = 1'b0;
        end
    endtask

    // monitor: compares each response against the scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            if (rsp_valid_o) begin
                if (sb_q.size() == 0) begin
                    check("R9 unexpected response", 32'(rsp_valid_o), 32'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check({e.tag, " store_ok"}, 32'(rsp_store_ok_o), 32'(e.so));
                    check({e.tag, " sc_ok"}, 32'(rsp_sc_ok_o), 32'(e.sc));
                    check({e.tag, " clr_excl"}, 32'(clr_excl_o), 32'(e.clr));
                end
            end else if (clr_excl_o != '0) begin
                check("R9 pulse without response", 32'(clr_excl_o), 32'd0);
            end
        end
    end

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < N; i++) begin m_v[i] = 1'b0; m_a[i] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset rsp_valid", 32'(rsp_valid_o), 32'd0);
        check("R10 reset store_ok", 32'(rsp_store_ok_o), 32'd0);
        check("R10 reset clr_excl", 32'(clr_excl_o), 32'd0);
        mon_on = 1'b1;

        issue(2'b10, 0, 1, 32'h100, "R10 no reservation after reset");
        issue(2'b01, 0, 1, 32'h1000, "R12 LL response");
        issue(2'b10, 0, 1, 32'h103C, "R1 R2 same line SC success");
        issue(2'b01, 1, 1, 32'h2000, "R12 LL response");
        issue(2'b10, 1, 1, 32'h2040, "R1 next line SC fail");
        issue(2'b01, 1, 1, 32'h3000, "R3 LL replace");
        issue(2'b10, 1, 1, 32'h2000, "R3 old line SC fail");
        issue(2'b01, 2, 1, 32'h3000, "R12 LL response");
        issue(2'b10, 2, 1, 32'h3008, "R8 SC notifies other owner");
        idle(2);
        issue(2'b01, 0, 1, 32'h4000, "R12 LL response");
        issue(2'b01, 3, 1, 32'h4000, "R12 LL response");
        issue(2'b10, 1, 1, 32'h4000, "R4 foreign reservation SC fail");
        issue(2'b10, 0, 1, 32'h5000, "R4 wrong line SC fail");
        issue(2'b10, 0, 0, 32'h4000, "R4 invalid ctx SC fail");
        issue(2'b10, 3, 1, 32'h4000, "R5 reservation kept after failed SC");
        issue(2'b01, 0, 1, 32'h6000, "R12 LL response");
        issue(2'b01, 1, 1, 32'h6000, "R12 LL response");
        issue(2'b01, 2, 1, 32'h7000, "R12 LL response");
        issue(2'b11, 2, 1, 32'h6010, "R6 R8 plain store clears line");
        issue(2'b10, 0, 1, 32'h6000, "R7 cleared reservation SC fail");
        issue(2'b10, 2, 1, 32'h7000, "R7 other line kept SC success");
        issue(2'b01, 0, 1, 32'h8000, "R12 LL response");
        issue(2'b01, 1, 1, 32'h8000, "R12 LL response");
        issue(2'b11, 0, 0, 32'h8020, "R8 contextless store notifies all");
        issue(2'b01, 3, 0, 32'h9000, "R11 LL without context");
        issue(2'b11, 0, 0, 32'h9000, "R11 nothing recorded");
        issue(2'b01, 0, 1, 32'hA000, "R12 LL response");
        issue(2'b00, 0, 1, 32'hA000, "R12 no-op response");
        issue(2'b10, 0, 1, 32'hA000, "R12 no-op kept reservation");
        idle(3);

        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            issue(lfsr[1:0], int'(lfsr[3:2]), (lfsr[6:4] != 3'b000),
                  32'h1_0000 + {lfsr[9:8], 6'b0} + 32'(lfsr[13:10]), "R9 mixed stream");
            if (lfsr[15:14] == 2'b00) idle(1);
        end
        idle(4);
        check("R9 all responses received", 32'(sb_q.size()), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule